// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds a small set of recently used page-table entries so that a virtual page number can be turned into a physical frame number without a table walk. A lookup presents a virtual page number together with the identifier of the running process. Every stored entry is compared with the lookup at the same time, and the block answers in the same cycle with a hit flag, the frame number and the permission and state bits of the matching entry.

After a miss, the walker outside the block writes the missing translation through the fill port. The fill goes to an unused slot if one exists. Otherwise it replaces a slot chosen by a rotating pointer. Entries carry the process identifier, so several address spaces can stay resident together. When the identifier is not in use, the tag-enable input is held low and the system flushes the whole buffer on every context switch.

Top module: `xlat_cache`

## Requirements
- R1: While reset is high and after it is released, every entry is invalid, so every lookup misses until a fill lands.
- R2: A lookup is combinational. It hits when a valid entry holds the presented page number and, in tagged mode, the presented identifier. In the same cycle it drives that entry's frame number and its 6-bit attribute word: bits [5:3] permission, bit 2 referenced, bit 1 modified, bit 0 cacheable.
- R3: With tag_en high, an entry whose stored identifier differs from the lookup identifier never hits, even when the page number matches.
- R4: With tag_en low, the identifier is ignored when lookups and fills are matched.
- R5: A fill is applied at the rising clock edge in which fill_en is sampled high. A lookup made in the same cycle as the fill still sees the old contents.
- R6: A fill that matches no stored entry goes to the lowest-numbered invalid slot when any slot is invalid. A new entry therefore displaces nothing while the buffer has room.
- R7: When all slots are valid, a fill that matches no stored entry replaces the slot named by a rotating pointer. The pointer starts at slot 0 on reset, moves to the next slot (wrapping after the last) only on such an evicting fill, and is not changed by a flush.
- R8: A fill whose page number (and identifier, in tagged mode) matches a valid entry rewrites that entry in place. It takes no free slot and does not move the pointer.
- R9: A flush invalidates every entry at the next edge. If a flush and a fill arrive in the same cycle, the flush wins and the fill is dropped.
- R10: On a miss, the frame number and attribute outputs are all zeros.
- R11: If several valid entries match a lookup, the lowest-numbered slot supplies the result. This can happen when tagged entries for different identifiers are later looked up with tag_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_en | input | 1 | High: identifiers take part in matching |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup process identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hit entry, zero on miss |
| lk_attr | output | 6 | Attribute word of the hit entry, zero on miss |
| fill_en | input | 1 | Write a translation at the next edge |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_asid | input | ASID_W | Fill process identifier |
| fill_pfn | input | PFN_W | Fill frame number |
| fill_attr | input | 6 | Fill attribute word |
| flush | input | 1 | Invalidate every entry |

## Verification
Directed sequences cover each distinct case. One fill looked up in the cycle it is written and in the cycle after separates the combinational read from the clocked write. The same page is tried under a foreign identifier with tagging on and then off, which tells tagged matching from untagged matching. Filling one more page than there are slots, and then rewriting a resident page, shows free-slot placement, rotating eviction and in-place update. A flush given together with a fill, and duplicate pages under different identifiers read with tagging off, cover flush priority and the lowest-slot rule. A long random stream over a narrow range of pages and identifiers then mixes hits, overwrites, evictions, flushes and mode changes, and compares every lookup against a model of the requirements kept in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Attribute word stored with every translation (6 bits).
  typedef struct packed {
    logic [2:0] perm;       // access permission
    logic       refd;       // referenced
    logic       dirty;      // modified
    logic       cacheable;  // caching allowed
  } xlat_attr_t;

  localparam int ATTR_W = $bits(xlat_attr_t);

endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             flush,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [VPN_W-1:0]                 wr_vpn,
  input  logic [ASID_W-1:0]                wr_asid,
  input  logic [PFN_W-1:0]                 wr_pfn,
  input  xlat_pkg::xlat_attr_t             wr_attr,
  output logic [ENTRIES-1:0]               vld,
  output logic [ENTRIES-1:0][VPN_W-1:0]    vpn_q,
  output logic [ENTRIES-1:0][ASID_W-1:0]   asid_q,
  output logic [ENTRIES-1:0][PFN_W-1:0]    pfn_q,
  output xlat_pkg::xlat_attr_t [ENTRIES-1:0] attr_q
);

  logic do_wr;
  assign do_wr = wr_en && !flush;

  // Valid bits: reset and flush clear every slot at once.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  // Payload: no reset, one write port, gated by the valid bits.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
      pfn_q[wr_idx]  <= wr_pfn;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> (vld == '0));

  // R5
  fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
    do_wr |=> vld[$past(wr_idx)]);

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_q,
  input  logic                           tag_en,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic                           any,
  output logic [IDX_W-1:0]               first_idx
);

  logic [ENTRIES-1:0] hit_vec;

  // One comparator per slot, all in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic vpn_eq;
    logic asid_ok;
    assign vpn_eq   = (vpn_q[g] == key_vpn);
    assign asid_ok  = !tag_en || (asid_q[g] == key_asid);
    assign hit_vec[g] = vld[g] && vpn_eq && asid_ok;
  end

  assign any = |hit_vec;

  // Lowest-numbered matching slot wins.
  always_comb begin
    first_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) first_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld,
  input  logic               flush,
  input  logic               alloc,
  output logic               full,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] free_idx;
  logic             evict;

  assign full  = &vld;
  assign evict = alloc && full && !flush;

  // Lowest free slot.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_idx = full ? ptr : free_idx;

  // Rotating pointer, moved only by evicting fills.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (evict) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R6
  free_first_chk: assert property (@(posedge clk) disable iff (rst)
    !full |-> !vld[victim_idx]);

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(ptr));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ATTR_W = xlat_pkg::ATTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_en,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              flush
);

  logic [ENTRIES-1:0]               vld;
  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]   asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]    pfn_q;
  xlat_pkg::xlat_attr_t [ENTRIES-1:0] attr_q;

  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic             fl_any;
  logic [IDX_W-1:0] fl_idx;
  logic             full;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;

  xlat_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_vpn  (fill_vpn),
    .wr_asid (fill_asid),
    .wr_pfn  (fill_pfn),
    .wr_attr (xlat_pkg::xlat_attr_t'(fill_attr)),
    .vld     (vld),
    .vpn_q   (vpn_q),
    .asid_q  (asid_q),
    .pfn_q   (pfn_q),
    .attr_q  (attr_q)
  );

  // Lookup compare bank.
  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .vld       (vld),
    .vpn_q     (vpn_q),
    .asid_q    (asid_q),
    .tag_en    (tag_en),
    .key_vpn   (lk_vpn),
    .key_asid  (lk_asid),
    .any       (lk_any),
    .first_idx (lk_idx)
  );

  // Fill compare bank: finds an entry to rewrite in place.
  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
    .vld       (vld),
    .vpn_q     (vpn_q),
    .asid_q    (asid_q),
    .tag_en    (tag_en),
    .key_vpn   (fill_vpn),
    .key_asid  (fill_asid),
    .any       (fl_any),
    .first_idx (fl_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst        (rst),
    .vld        (vld),
    .flush      (flush),
    .alloc      (fill_en && !fl_any),
    .full       (full),
    .victim_idx (victim_idx)
  );

  assign wr_en  = fill_en;
  assign wr_idx = fl_any ? fl_idx : victim_idx;

  assign lk_hit  = lk_any;
  assign lk_pfn  = lk_any ? pfn_q[lk_idx] : '0;
  assign lk_attr = lk_any ? ATTR_W'(attr_q[lk_idx]) : '0;

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);

  // R8
  overwrite_in_place_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush && fl_any) |=> $stable(vld));

  // R6
  no_evict_with_room_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush && !full) |=> ($countones(vld) >= $countones($past(vld))));

endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

  localparam int N  = 16;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tag_en = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic lk_hit;
  logic [PW-1:0] lk_pfn;
  logic [5:0] lk_attr;
  logic fill_en = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [5:0] fill_attr = '0;
  logic flush = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) i_xlat_cache (
    .clk(clk), .rst(rst), .tag_en(tag_en),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_attr(lk_attr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_attr(fill_attr), .flush(flush)
  );

  // Reference model of the requirements.
  logic          m_vld  [N];
  logic [VW-1:0] m_vpn  [N];
  logic [AW-1:0] m_asid [N];
  logic [PW-1:0] m_pfn  [N];
  logic [5:0]    m_attr [N];
  int            m_ptr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  function automatic int model_find(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic t);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == v && (!t || m_asid[i] == a)) return i;
    return -1;
  endfunction

  function automatic int model_free();
    for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  // One cycle: drive at the falling edge, check the combinational lookup,
  // then advance the model to the state after the next rising edge.
  task automatic step(input string lbl, input logic t,
                      input logic [VW-1:0] lv, input logic [AW-1:0] la,
                      input logic fe, input logic [VW-1:0] fv, input logic [AW-1:0] fa,
                      input logic [PW-1:0] fp, input logic [5:0] fat, input logic fl);
    int k;
    logic          e_hit;
    logic [PW-1:0] e_pfn;
    logic [5:0]    e_attr;
    @(negedge clk);
    tag_en = t; lk_vpn = lv; lk_asid = la;
    fill_en = fe; fill_vpn = fv; fill_asid = fa; fill_pfn = fp; fill_attr = fat;
    flush = fl;
    #1;
    k = model_find(lv, la, t);
    e_hit  = (k >= 0);
    e_pfn  = e_hit ? m_pfn[k]  : '0;
    e_attr = e_hit ? m_attr[k] : '0;
    vectors++;
    if (lk_hit !== e_hit || lk_pfn !== e_pfn || lk_attr !== e_attr) begin
      errors++;
      $display("FAIL %s: vpn=%0h asid=%0h got hit=%b pfn=%0h attr=%0h exp hit=%b pfn=%0h attr=%0h",
               lbl, lv, la, lk_hit, lk_pfn, lk_attr, e_hit, e_pfn, e_attr);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    end else if (fe) begin
      k = model_find(fv, fa, t);
      if (k < 0) k = model_free();
      if (k < 0) begin
        k = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_vld[k] = 1'b1; m_vpn[k] = fv; m_asid[k] = fa; m_pfn[k] = fp; m_attr[k] = fat;
    end
  endtask

  task automatic look(input string lbl, input logic t, input logic [VW-1:0] v, input logic [AW-1:0] a);
    step(lbl, t, v, a, 1'b0, '0, '0, '0, '0, 1'b0);
  endtask

  task automatic put(input string lbl, input logic t, input logic [VW-1:0] v, input logic [AW-1:0] a,
                     input logic [PW-1:0] p, input logic [5:0] at);
    // lookup of the same key in the fill cycle: old contents (R5)
    step(lbl, t, v, a, 1'b1, v, a, p, at, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250117));
    model_reset();
    repeat (3) @(posedge clk);
    // R1: lookups miss during reset
    look("R1 in reset", 1'b0, 20'h0, 8'h0);
    look("R1 in reset", 1'b1, 20'h5, 8'h1);
    @(negedge clk); rst = 1'b0;
    look("R1 after reset", 1'b0, 20'h0, 8'h0);
    look("R10 miss zero", 1'b1, 20'h123, 8'h3);

    // R5 / R2: fill then hit
    put ("R5 fill cycle", 1'b1, 20'h5, 8'h1, 20'hABCDE, 6'b101_1_0_1);
    look("R2 hit", 1'b1, 20'h5, 8'h1);
    look("R3 foreign id", 1'b1, 20'h5, 8'h2);
    look("R4 untagged", 1'b0, 20'h5, 8'h2);

    // R6: fill remaining slots, nothing displaced
    for (int i = 1; i < N; i++) put("R6 fill", 1'b1, 20'(100 + i), 8'h1, 20'(i * 7), 6'(i));
    look("R6 first kept", 1'b1, 20'h5, 8'h1);
    for (int i = 1; i < N; i++) look("R6 all resident", 1'b1, 20'(100 + i), 8'h1);

    // R7: full, eviction rotates from slot 0
    put ("R7 evict0", 1'b1, 20'h300, 8'h1, 20'h11111, 6'h3F);
    look("R7 slot0 gone", 1'b1, 20'h5, 8'h1);
    look("R7 new hit", 1'b1, 20'h300, 8'h1);
    put ("R7 evict1", 1'b1, 20'h301, 8'h1, 20'h22222, 6'h15);
    look("R7 slot1 gone", 1'b1, 20'(101), 8'h1);

    // R8: overwrite resident page in place
    put ("R8 overwrite", 1'b1, 20'(105), 8'h1, 20'h55555, 6'h2A);
    look("R8 new data", 1'b1, 20'(105), 8'h1);
    put ("R8 ptr kept", 1'b1, 20'h302, 8'h1, 20'h33333, 6'h01);
    look("R8 slot2 evicted", 1'b1, 20'(102), 8'h1);
    look("R8 overwritten kept", 1'b1, 20'(105), 8'h1);

    // R9: flush beats fill
    step("R9 flush+fill", 1'b1, 20'h300, 8'h1, 1'b1, 20'h777, 8'h1, 20'h1, 6'h1, 1'b1);
    look("R9 flushed", 1'b1, 20'h300, 8'h1);
    look("R9 fill dropped", 1'b1, 20'h777, 8'h1);

    // R11: duplicates under different ids, untagged lookup takes lowest slot
    put ("R11 id1", 1'b1, 20'h7, 8'h1, 20'hAAAAA, 6'h11);
    put ("R11 id2", 1'b1, 20'h7, 8'h2, 20'hBBBBB, 6'h22);
    look("R11 lowest", 1'b0, 20'h7, 8'h2);
    look("R3 id2 tagged", 1'b1, 20'h7, 8'h2);

    // Random mix
    begin
      logic t = 1'b1;
      for (int n = 0; n < 4000; n++) begin
        logic fe, fl;
        if ($urandom_range(0, 99) < 3) t = ~t;
        fe = ($urandom_range(0, 99) < 40);
        fl = ($urandom_range(0, 199) < 3);
        step(t ? "R3 random tagged" : "R4 random untagged", t,
             20'($urandom_range(0, 23)), 8'($urandom_range(0, 3)),
             fe, 20'($urandom_range(0, 23)), 8'($urandom_range(0, 3)),
             20'($urandom), 6'($urandom_range(0, 63)), fl);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule